// File: doc/BRIEF.md
# IDE Channel Timing Configuration Window

This block sits on the byte-wide register port of one IDE channel. In its normal state every read and write at the eight port offsets goes to a small task-file register stub. A fixed access pattern, two 16-bit reads at offset 1 followed by an 8-bit key write at offset 2, switches the same eight offsets over to a hidden configuration window. Software uses this window to program transfer timing for the two drives on the channel and then returns the port to normal operation with a second key write.

Inside the window there are two staged timing sets, one per drive. Each set holds a read-cycle byte and a write-cycle byte. There is also a miscellaneous byte, a control byte and a read-only strap byte. The low bit of the miscellaneous byte picks which drive's staged set takes the timing writes. Its upper seven bits hold an address-setup value that both drives share. Staged values reach the output ports only when a commit key is written to the control byte. A downstream bus-cycle generator can therefore never see a half-programmed set.

Top module: `ide_cfg_window`

## Requirements
- R1: After a synchronous reset, the window is locked (`window_open` = 0). Every committed and staged timing byte is 0xFF, `addr_setup` is 0x7F, and `bus_rdata` is 0.
- R2: While locked, a write at any offset stores its low data byte in the task-file stub. A later read at that offset returns the byte zero-extended to 16 bits, one cycle after the read strobe.
- R3: The window opens on this access pattern: a 16-bit read at offset 1, then another 16-bit read at offset 1, then an 8-bit write of 0x03 at offset 2. `window_open` rises in the cycle after the key write. The key write does not reach the task file.
- R4: Any access that is not the next expected step sends the unlock detector back to idle. An 8-bit read counts as a wrong step where a 16-bit read is expected. A key write that arrives after a broken pattern is an ordinary task-file write.
- R5: After the two 16-bit reads at offset 1, a read at offset 5 returns the strap input in bit 0 (0 = 33 MHz bus clock, 1 = 25 MHz) while the window is still locked. Other offsets still return task-file data.
- R6: While open, bit 0 of the miscellaneous byte (offset 6) selects drive 0 or drive 1. Writes at offset 0 (read timing) and offset 1 (write timing) go to that drive's staged set. Reads at those offsets return the selected drive's staged set.
- R7: The timing and address-setup output ports change only on a write of 0x85 to the control byte (offset 3) while open. That write copies staged set 0 to drive 0, staged set 1 to drive 1, and bits 7:1 of the miscellaneous byte to `addr_setup`.
- R8: A control write of any value other than 0x85 is stored and can be read back at offset 3, but it leaves every output port unchanged.
- R9: `addr_setup` is one shared value for both drives. It is taken from the miscellaneous byte that was last written before the commit, whichever drive that write selected.
- R10: While open, an 8-bit write of 0x83 at offset 2 closes the window in the next cycle. No write made while open, including the close write itself, changes the task-file contents.
- R11: The strap byte at offset 5 is read-only: a write there while open has no effect on what offset 5 returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, never together with `bus_rd` |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | 3 | Port offset |
| bus_wdata | input | 8 | Write data |
| strap_clk25 | input | 1 | Static bus-clock strap: 1 = 25 MHz, 0 = 33 MHz |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| window_open | output | 1 | High while the configuration window is unlocked |
| dev_rd_timing | output | NDEV*8 | Committed read-cycle timing; byte n belongs to drive n |
| dev_wr_timing | output | NDEV*8 | Committed write-cycle timing; byte n belongs to drive n |
| addr_setup | output | 7 | Committed shared address-setup value |

## Verification
The bench builds the block with its default parameters: two drives, eight-bit timing bytes and a reset timing value of 0xFF. With two drives, the one-bit selector in the miscellaneous byte must reach both staged sets. Per-drive steering, partial commits and the shared address-setup field are all checked against distinct values. Each way of breaking the unlock pattern is tried: a narrow read, a stray read and a strap read. So are both strap polarities, and a window left open across writes at every configuration offset.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int RDATA_W  = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] KEY_UNLOCK = 8'h03;
    localparam logic [BYTE_W-1:0] KEY_RELOCK = 8'h83;
    localparam logic [BYTE_W-1:0] KEY_COMMIT = 8'h85;

    localparam logic [ADDR_W-1:0] OFF_RDTIM = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_WRTIM = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MISC  = 3'd6;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2,
        SEQ_OPEN = 2'd3
    } seq_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rd_tim;
        logic [BYTE_W-1:0] wr_tim;
    } tim_set_t;

    function automatic logic is_probe_read(bus_req_t r);
        return r.rd && r.wide && (r.addr == OFF_WRTIM);
    endfunction

    function automatic logic is_key_write(bus_req_t r, logic [BYTE_W-1:0] key);
        return r.wr && !r.wide && (r.addr == OFF_KEY) && (r.wdata == key);
    endfunction

endpackage

// File: rtl/ide_unlock_fsm.sv
module ide_unlock_fsm
    import ide_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output seq_e     state
);

    seq_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: if (is_probe_read(req)) state_nx = SEQ_ONE;
            SEQ_ONE: begin
                if (req.rd || req.wr)
                    state_nx = is_probe_read(req) ? SEQ_TWO : SEQ_IDLE;
            end
            SEQ_TWO: begin
                if (req.rd || req.wr)
                    state_nx = is_key_write(req, KEY_UNLOCK) ? SEQ_OPEN : SEQ_IDLE;
            end
            SEQ_OPEN: if (is_key_write(req, KEY_RELOCK)) state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/ide_taskfile_stub.sv
module ide_taskfile_stub
    import ide_win_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (addr == ADDR_W'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[addr];

endmodule

// File: rtl/ide_timing_bank.sv
module ide_timing_bank
    import ide_win_pkg::*;
#(
    parameter int                NDEV      = 2,
    parameter logic [BYTE_W-1:0] TIM_RESET = 8'hFF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_rdtim,
    input  logic                         wr_wrtim,
    input  logic                         wr_ctrl,
    input  logic                         wr_misc,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [BYTE_W-1:0]            sel_rdtim,
    output logic [BYTE_W-1:0]            sel_wrtim,
    output logic [BYTE_W-1:0]            ctrl_q,
    output logic [BYTE_W-1:0]            misc_q,
    output logic [NDEV*BYTE_W-1:0]       act_rd,
    output logic [NDEV*BYTE_W-1:0]       act_wr,
    output logic [BYTE_W-$clog2(NDEV)-1:0] act_asu
);

    localparam int DEVSEL_W = $clog2(NDEV);
    localparam int ASU_W    = BYTE_W - DEVSEL_W;

    tim_set_t             staged [NDEV];
    tim_set_t             active [NDEV];
    logic [DEVSEL_W-1:0]  devsel;
    logic                 commit;

    assign devsel = misc_q[DEVSEL_W-1:0];
    assign commit = wr_ctrl && (wdata == KEY_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            misc_q  <= '0;
            act_asu <= '1;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_misc) misc_q <= wdata;
            if (commit)  act_asu <= misc_q[BYTE_W-1:DEVSEL_W];
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        logic here;
        assign here = (devsel == DEVSEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                staged[g] <= '{rd_tim: TIM_RESET, wr_tim: TIM_RESET};
                active[g] <= '{rd_tim: TIM_RESET, wr_tim: TIM_RESET};
            end else begin
                if (wr_rdtim && here) staged[g].rd_tim <= wdata;
                if (wr_wrtim && here) staged[g].wr_tim <= wdata;
                if (commit)           active[g]        <= staged[g];
            end
        end

        assign act_rd[g*BYTE_W +: BYTE_W] = active[g].rd_tim;
        assign act_wr[g*BYTE_W +: BYTE_W] = active[g].wr_tim;
    end

    assign sel_rdtim = staged[devsel].rd_tim;
    assign sel_wrtim = staged[devsel].wr_tim;

    logic unused_w;
    assign unused_w = (ASU_W == 0);

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import ide_win_pkg::*;
#(
    parameter int                NDEV      = 2,
    parameter logic [BYTE_W-1:0] TIM_RESET = 8'hFF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_rd,
    input  logic                           bus_wr,
    input  logic                           bus_wide,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [BYTE_W-1:0]              bus_wdata,
    input  logic                           strap_clk25,
    output logic [RDATA_W-1:0]             bus_rdata,
    output logic                           window_open,
    output logic [NDEV*BYTE_W-1:0]         dev_rd_timing,
    output logic [NDEV*BYTE_W-1:0]         dev_wr_timing,
    output logic [BYTE_W-$clog2(NDEV)-1:0] addr_setup
);

    bus_req_t          req;
    seq_e              state;
    logic              is_open;
    logic              tf_we;
    logic              cfg_wr;
    logic [BYTE_W-1:0] tf_rdata;
    logic [BYTE_W-1:0] sel_rdtim, sel_wrtim, ctrl_q, misc_q;
    logic [BYTE_W-1:0] strap_byte;
    logic [BYTE_W-1:0] rd_byte;

    assign req = '{rd: bus_rd, wr: bus_wr, wide: bus_wide,
                   addr: bus_addr, wdata: bus_wdata};

    ide_unlock_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .state (state)
    );

    assign is_open     = (state == SEQ_OPEN);
    assign window_open = is_open;
    assign strap_byte  = {{(BYTE_W-1){1'b0}}, strap_clk25};

    assign tf_we  = bus_wr && !is_open &&
                    !((state == SEQ_TWO) && is_key_write(req, KEY_UNLOCK));
    assign cfg_wr = bus_wr && is_open;

    ide_taskfile_stub u_tf (
        .clk   (clk),
        .rst   (rst),
        .we    (tf_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (tf_rdata)
    );

    ide_timing_bank #(.NDEV(NDEV), .TIM_RESET(TIM_RESET)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_rdtim  (cfg_wr && (bus_addr == OFF_RDTIM)),
        .wr_wrtim  (cfg_wr && (bus_addr == OFF_WRTIM)),
        .wr_ctrl   (cfg_wr && (bus_addr == OFF_CTRL)),
        .wr_misc   (cfg_wr && (bus_addr == OFF_MISC)),
        .wdata     (bus_wdata),
        .sel_rdtim (sel_rdtim),
        .sel_wrtim (sel_wrtim),
        .ctrl_q    (ctrl_q),
        .misc_q    (misc_q),
        .act_rd    (dev_rd_timing),
        .act_wr    (dev_wr_timing),
        .act_asu   (addr_setup)
    );

    always_comb begin
        rd_byte = tf_rdata;
        if (is_open) begin
            unique case (bus_addr)
                OFF_RDTIM: rd_byte = sel_rdtim;
                OFF_WRTIM: rd_byte = sel_wrtim;
                OFF_CTRL:  rd_byte = ctrl_q;
                OFF_STRAP: rd_byte = strap_byte;
                OFF_MISC:  rd_byte = misc_q;
                default:   rd_byte = '0;
            endcase
        end else if ((state == SEQ_TWO) && (bus_addr == OFF_STRAP)) begin
            rd_byte = strap_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= {{(RDATA_W-BYTE_W){1'b0}}, rd_byte};
    end

endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk
    import ide_win_pkg::*;
#(
    parameter int NDEV = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_rd,
    input logic                           bus_wr,
    input logic                           bus_wide,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [BYTE_W-1:0]              bus_wdata,
    input logic                           strap_clk25,
    input logic [RDATA_W-1:0]             bus_rdata,
    input logic                           window_open,
    input logic [NDEV*BYTE_W-1:0]         dev_rd_timing,
    input logic [NDEV*BYTE_W-1:0]         dev_wr_timing,
    input logic [BYTE_W-$clog2(NDEV)-1:0] addr_setup
);

    logic key_unlock_wr, key_relock_wr, commit_wr;
    assign key_unlock_wr = bus_wr && !bus_wide && bus_addr == OFF_KEY && bus_wdata == KEY_UNLOCK;
    assign key_relock_wr = bus_wr && !bus_wide && bus_addr == OFF_KEY && bus_wdata == KEY_RELOCK;
    assign commit_wr     = bus_wr && window_open && bus_addr == OFF_CTRL && bus_wdata == KEY_COMMIT;

    p_open_by_key_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(window_open) |-> $past(key_unlock_wr));

    p_close_by_key_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(window_open) |-> $past(key_relock_wr));

    // R8 also rests on this: non-commit control writes leave outputs still
    p_hold_until_commit_r7: assert property (@(posedge clk) disable iff (rst)
        !commit_wr |=> ($stable(dev_rd_timing) && $stable(dev_wr_timing) && $stable(addr_setup)));

    p_strap_reads_r11: assert property (@(posedge clk) disable iff (rst)
        (window_open && bus_rd && bus_addr == OFF_STRAP)
            |=> (bus_rdata == {{(RDATA_W-1){1'b0}}, strap_clk25}));

    p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

endmodule

bind ide_cfg_window ide_cfg_window_chk #(.NDEV(NDEV)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wide      (bus_wide),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .strap_clk25   (strap_clk25),
    .bus_rdata     (bus_rdata),
    .window_open   (window_open),
    .dev_rd_timing (dev_rd_timing),
    .dev_wr_timing (dev_wr_timing),
    .addr_setup    (addr_setup)
);

// File: tb/tb_ide_cfg_window.sv
module tb_ide_cfg_window;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        strap_clk25 = 1'b0;
    logic [15:0] bus_rdata;
    logic        window_open;
    logic [15:0] dev_rd_timing, dev_wr_timing;
    logic [6:0]  addr_setup;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ide_cfg_window dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .strap_clk25(strap_clk25),
        .bus_rdata(bus_rdata), .window_open(window_open),
        .dev_rd_timing(dev_rd_timing), .dev_wr_timing(dev_wr_timing),
        .addr_setup(addr_setup)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic wide, output logic [15:0] d);
        bus_rd = 1'b1; bus_wide = wide; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_wide = 1'b0; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic unlock();
        logic [15:0] d;
        rd(3'd1, 1'b1, d);
        rd(3'd1, 1'b1, d);
        wr(3'd2, 8'h03);
    endtask

    task automatic t_reset();
        check("R1 open", window_open, 0);
        check("R1 rd timing", dev_rd_timing, 16'hFFFF);
        check("R1 wr timing", dev_wr_timing, 16'hFFFF);
        check("R1 addr setup", addr_setup, 7'h7F);
        check("R1 rdata", bus_rdata, 0);
    endtask

    task automatic t_taskfile();
        logic [15:0] d;
        wr(3'd0, 8'h11);
        wr(3'd2, 8'h5A);
        wr(3'd5, 8'hC3);
        rd(3'd0, 1'b0, d); check("R2 tf off0", d, 16'h0011);
        rd(3'd2, 1'b1, d); check("R2 tf off2 wide", d, 16'h005A);
        rd(3'd5, 1'b0, d); check("R2 tf off5", d, 16'h00C3);
    endtask

    task automatic t_broken();
        logic [15:0] d;
        rd(3'd1, 1'b1, d); rd(3'd1, 1'b1, d);
        rd(3'd3, 1'b0, d);
        wr(3'd2, 8'h03);
        check("R4 stray read keeps lock", window_open, 0);
        rd(3'd2, 1'b0, d); check("R4 key lands in tf", d, 16'h0003);
        rd(3'd1, 1'b1, d); rd(3'd1, 1'b0, d); rd(3'd1, 1'b1, d);
        wr(3'd2, 8'h03);
        check("R4 narrow read keeps lock", window_open, 0);
        wr(3'd2, 8'h5A);
    endtask

    task automatic t_strap();
        logic [15:0] d;
        strap_clk25 = 1'b1;
        rd(3'd1, 1'b1, d); rd(3'd1, 1'b1, d);
        rd(3'd5, 1'b0, d); check("R5 strap 25MHz", d, 16'h0001);
        check("R5 still locked", window_open, 0);
        rd(3'd5, 1'b0, d); check("R5 strap hidden again", d, 16'h00C3);
        strap_clk25 = 1'b0;
        rd(3'd1, 1'b1, d); rd(3'd1, 1'b1, d);
        rd(3'd5, 1'b0, d); check("R5 strap 33MHz", d, 16'h0000);
        wr(3'd2, 8'h03);
        check("R4 strap read breaks pattern", window_open, 0);
        wr(3'd2, 8'h5A);
        strap_clk25 = 1'b1;
    endtask

    task automatic t_program();
        logic [15:0] d;
        unlock();
        check("R3 window opens", window_open, 1);
        rd(3'd0, 1'b0, d); check("R3 window replaces tf", d, 16'h00FF);
        wr(3'd6, 8'h20);
        wr(3'd0, 8'h59); wr(3'd1, 8'h46);
        wr(3'd6, 8'h21);
        wr(3'd0, 8'h32); wr(3'd1, 8'h20);
        rd(3'd0, 1'b0, d); check("R6 dev1 staged rd", d, 16'h0032);
        rd(3'd1, 1'b1, d); check("R6 dev1 staged wr", d, 16'h0020);
        wr(3'd6, 8'h30);
        rd(3'd0, 1'b0, d); check("R6 dev0 staged rd", d, 16'h0059);
        rd(3'd1, 1'b0, d); check("R6 dev0 staged wr", d, 16'h0046);
        wr(3'd6, 8'h31);
        check("R7 no change before commit", dev_rd_timing, 16'hFFFF);
        wr(3'd3, 8'h84);
        check("R8 non-key ctrl no commit", dev_wr_timing, 16'hFFFF);
        check("R8 non-key ctrl asu", addr_setup, 7'h7F);
        rd(3'd3, 1'b0, d); check("R8 ctrl readback", d, 16'h0084);
        wr(3'd3, 8'h85);
        check("R7 commit rd timing", dev_rd_timing, 16'h3259);
        check("R7 commit wr timing", dev_wr_timing, 16'h2046);
        check("R9 shared addr setup", addr_setup, 7'h18);
        wr(3'd5, 8'hAA);
        rd(3'd5, 1'b0, d); check("R11 strap read-only", d, 16'h0001);
        wr(3'd2, 8'h83);
        check("R10 window closes", window_open, 0);
        rd(3'd0, 1'b0, d); check("R10 tf off0 untouched", d, 16'h0011);
        rd(3'd2, 1'b0, d); check("R10 key writes not in tf", d, 16'h005A);
        rd(3'd5, 1'b0, d); check("R10 tf off5 untouched", d, 16'h00C3);
        check("R7 outputs kept after close", dev_rd_timing, 16'h3259);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_taskfile();
        t_broken();
        t_strap();
        t_program();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule